// File: doc/BRIEF.md
# Bit-Slip Word Realigning Deserializer

This block receives one serial bit on every fast-clock edge and turns the stream into parallel words. The word width can be 4, 6, 7, 8 or 10 bits. A one-cycle word strobe marks each new word and takes the place of a slow parallel clock. Ahead of the word assembler, a bit-slip delay line can add from zero up to ten bit-times of latency. Each rising edge of an align request adds one more bit-time, so the word boundary moves by one bit each time. Software or a training state machine keeps pulsing the request until the received words line up with a known pattern.

The delay count wraps back to zero at a programmable rollover point between 1 and 11, which is set apart from the word width. On the wrap, a status output stays high for one whole word period. A configuration whose rollover point is smaller than the word width cannot slip a full word and is flagged as an error. A bypass mode skips both slipping and assembly and passes raw captured bits out, two per cycle for DDR or one per cycle for SDR.

Top module: `bitslip_deser`

## Requirements
- R1: While reset is low and right after it, `word_o`, `wstb_o` and `roll_o` are 0 and the slip count is 0. The first `wstb_o` pulse follows exactly one word width of fast-clock edges after reset is released.
- R2: `wstb_o` is high for one cycle out of every F cycles, where F is the word width. With it, `word_o[F-1:0]` holds the last F delayed bits, with the earliest received bit in bit F-1. Bits above F-1 read 0.
- R3: `fsel` selects the word width: 0 gives 4, 1 gives 6, 2 gives 7, 3 gives 8 and 4 gives 10. Codes 5 to 7 raise `cfg_err_o`, and then no word strobes appear.
- R4: `cfg_err_o` is also raised when `rpt` is 0, when `rpt` is above 11, or when `rpt` is below F. While it is high, no strobes are produced.
- R5: `align_req` is sampled once per word, at the boundary edge. A 0-to-1 change between two samples adds one bit-time of delay, which applies from the next bit onward. A request held high causes exactly one slip.
- R6: When a slip would make the count equal `rpt`, the count returns to 0. At the same time `roll_o` goes high for exactly F cycles, aligned with the word strobe period.
- R7: Any change of `fsel`, `rpt` or `byp_en` clears the slip count and the roll status. The bit sampled on that edge is dropped, and framing restarts so that the next strobe comes F bits later.
- R8: When `byp_en` is 1, `byp_o` shows the bits captured at the previous edge. With `byp_ddr` = 1 it is {`sin`, `sin_b`}, with `sin` in bit 1. With `byp_ddr` = 0 it is {0, `sin`}. No word strobes occur in bypass, and `byp_o` is 0 when bypass is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sin | input | 1 | Serial data bit (rising-edge sample in DDR bypass) |
| sin_b | input | 1 | Second-half data bit, used in DDR bypass only |
| align_req | input | 1 | Slip request, acted on at its rising edge |
| byp_en | input | 1 | Bypass the slip logic and assembler |
| byp_ddr | input | 1 | In bypass: 1 = two bits per cycle, 0 = one bit |
| fsel | input | 3 | Word width code |
| rpt | input | 4 | Rollover point in bit-times |
| word_o | output | 10 | Assembled word, right-aligned |
| wstb_o | output | 1 | One-cycle strobe for a new word |
| roll_o | output | 1 | High for one word period after a wrap |
| cfg_err_o | output | 1 | Illegal width code or rollover point |
| byp_o | output | 2 | Raw captured bits in bypass |

## Verification
Random serial data runs through every legal width, against a reference model that keeps a history of received bits. Any off-by-one in the delay tap or in the bit order inside a word shows up as a data mismatch. Two kinds of align stimulus are used: a long held-high request and a train of short pulses. These separate edge detection from level sensing and drive the count into its wrap, so the length of the roll pulse is checked for both narrow and wide words. Configuration changes in mid-word, illegal codes, rollover points below the width, and both bypass variants check that framing restarts correctly and that the assembler stays silent.

// File: rtl/bitslip_deser.sv
`timescale 1ns/1ps
module bitslip_deser #(
  parameter int MAX_W    = 10,
  parameter int MAX_SLIP = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sin,
  input  logic                       sin_b,
  input  logic                       align_req,
  input  logic                       byp_en,
  input  logic                       byp_ddr,
  input  logic [2:0]                 fsel,
  input  logic [$clog2(MAX_SLIP+1)-1:0] rpt,
  output logic [MAX_W-1:0]           word_o,
  output logic                       wstb_o,
  output logic                       roll_o,
  output logic                       cfg_err_o,
  output logic [1:0]                 byp_o
);
  localparam int CW = $clog2(MAX_W);
  localparam int SW = $clog2(MAX_SLIP+1);
  localparam int GW = 1 + 3 + SW;

  function automatic logic [CW:0] fac_of(input logic [2:0] s);
    case (s)
      3'd0: return (CW+1)'(4);
      3'd1: return (CW+1)'(6);
      3'd2: return (CW+1)'(7);
      3'd3: return (CW+1)'(8);
      3'd4: return (CW+1)'(10);
      default: return '0;
    endcase
  endfunction

  logic [CW:0]         fac;
  logic [GW-1:0]       cfg_now, cfg_q;
  logic                cfg_chg, hold, at_bnd, rise, dbit;
  logic [CW-1:0]       cnt_q;
  logic [SW-1:0]       slip_q;
  logic                aprev_q, cap_a, cap_b;
  logic [MAX_SLIP-1:0] dl;
  logic [MAX_W-2:0]    sh;
  logic [MAX_W-1:0]    next_sh, mask;

  assign fac       = fac_of(fsel);
  assign cfg_err_o = (fac == '0) || (int'(fac) > MAX_W) || (rpt == '0) ||
                     (int'(rpt) > MAX_SLIP) || (int'(rpt) < int'(fac));
  assign cfg_now   = {byp_en, fsel, rpt};
  assign cfg_chg   = cfg_now != cfg_q;
  assign hold      = cfg_err_o || byp_en;
  assign at_bnd    = {1'b0, cnt_q} == fac - 1'b1;
  assign rise      = align_req && !aprev_q;
  assign next_sh   = {sh, dbit};
  assign byp_o     = !byp_en ? 2'b00 : byp_ddr ? {cap_a, cap_b} : {1'b0, cap_a};

  always_comb begin
    dbit = sin;
    if (slip_q != '0 && int'(slip_q) <= MAX_SLIP) dbit = dl[slip_q - 1'b1];
  end

  always_comb
    for (int i = 0; i < MAX_W; i++) mask[i] = i < int'(fac);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= cfg_now;
      cnt_q   <= '0;
      slip_q  <= '0;
      aprev_q <= 1'b0;
      dl      <= '0;
      sh      <= '0;
      word_o  <= '0;
      wstb_o  <= 1'b0;
      roll_o  <= 1'b0;
      cap_a   <= 1'b0;
      cap_b   <= 1'b0;
    end else begin
      dl    <= {dl[MAX_SLIP-2:0], sin};
      cap_a <= sin;
      cap_b <= sin_b;
      if (cfg_chg || hold) begin
        cfg_q   <= cfg_now;
        cnt_q   <= '0;
        slip_q  <= '0;
        aprev_q <= 1'b0;
        wstb_o  <= 1'b0;
        roll_o  <= 1'b0;
      end else begin
        sh     <= next_sh[MAX_W-2:0];
        wstb_o <= at_bnd;
        if (at_bnd) begin
          cnt_q   <= '0;
          word_o  <= next_sh & mask;
          aprev_q <= align_req;
          if (rise && slip_q + 1'b1 == rpt) begin
            slip_q <= '0;
            roll_o <= 1'b1;
          end else begin
            if (rise) slip_q <= slip_q + 1'b1;
            roll_o <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wstb_o |=> !wstb_o);                                             // R2
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |=> !wstb_o && !roll_o);                               // R3
  AST_SLIP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_err_o |-> int'(slip_q) < int'(rpt));                        // R4
  AST_SLIP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slip_q) |-> slip_q == '0 || slip_q == $past(slip_q) + 1'b1); // R5
  AST_ROLL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(roll_o) |-> slip_q == '0 && wstb_o);                       // R6
  AST_CHG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> slip_q == '0 && !wstb_o && !roll_o);                 // R7
  AST_BYP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    byp_en |=> !wstb_o);                                             // R8
endmodule

// File: tb/test_bitslip_deser.sv
`timescale 1ns/1ps
module test_bitslip_deser;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sin = 1'b0, sin_b = 1'b0, align_req = 1'b0, byp_en = 1'b0, byp_ddr = 1'b0;
  logic [2:0] fsel = 3'd0;
  logic [3:0] rpt = 4'd4;
  logic [9:0] word_o;
  logic wstb_o, roll_o, cfg_err_o;
  logic [1:0] byp_o;
  int checks = 0, fails = 0;
  string tag = "R2";
  bit done = 0;

  always #4 clk = ~clk;

  bitslip_deser i_bitslip_deser (.clk, .rst_n, .sin, .sin_b, .align_req, .byp_en,
    .byp_ddr, .fsel, .rpt, .word_o, .wstb_o, .roll_o, .cfg_err_o, .byp_o);

  function automatic int ref_fac(input logic [2:0] s);
    case (s) 0: return 4; 1: return 6; 2: return 7; 3: return 8; 4: return 10; default: return 0; endcase
  endfunction
  function automatic bit ref_err();
    int f = ref_fac(fsel);
    return f == 0 || rpt == 0 || rpt > 11 || int'(rpt) < f;
  endfunction

  // behavioural reference
  int m_cnt, m_slip, m_acc;
  bit m_roll, m_wstb, m_aprev, m_capa, m_capb;
  logic [9:0] m_word;
  logic [15:0] m_hist;
  logic [7:0] m_cfgq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_slip = 0; m_acc = 0; m_roll = 0; m_wstb = 0; m_aprev = 0;
      m_capa = 0; m_capb = 0; m_word = 0; m_hist = 0; m_cfgq = {byp_en, fsel, rpt};
    end else begin
      bit b;
      int f;
      f = ref_fac(fsel);
      b = (m_slip == 0) ? sin : m_hist[m_slip-1];
      m_hist = {m_hist[14:0], sin};
      m_capa = sin; m_capb = sin_b;
      if ({byp_en, fsel, rpt} != m_cfgq || ref_err() || byp_en) begin
        m_cfgq = {byp_en, fsel, rpt};
        m_cnt = 0; m_slip = 0; m_roll = 0; m_wstb = 0; m_aprev = 0;
      end else begin
        m_acc = (m_acc << 1) | int'(b);
        m_cnt++;
        if (m_cnt == f) begin
          m_word = 10'(m_acc & ((1 << f) - 1));
          m_wstb = 1; m_cnt = 0;
          if (align_req && !m_aprev) begin
            if (m_slip + 1 == int'(rpt)) begin m_slip = 0; m_roll = 1; end
            else begin m_slip++; m_roll = 0; end
          end else m_roll = 0;
          m_aprev = align_req;
        end else m_wstb = 0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk({tag, " word"}, word_o, m_word);
    chk({tag, " strobe"}, wstb_o, m_wstb);
    chk("R6 roll", roll_o, m_roll);
    chk("R3 R4 cfg_err", cfg_err_o, ref_err());
    chk("R8 bypass", byp_o, !byp_en ? 0 : byp_ddr ? {m_capa, m_capb} : {1'b0, m_capa});
  end

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk); #1;
      sin = 1'($urandom); sin_b = 1'($urandom);
    end
  endtask

  task automatic report();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    int first;
    step(4);
    tag = "R1";
    chk("R1 reset word", word_o, 0);
    chk("R1 reset strobe", wstb_o, 0);
    chk("R1 reset roll", roll_o, 0);
    rst_n = 1'b1;
    first = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (wstb_o && first == 0) first = i;
      #1 sin = 1'($urandom);
    end
    chk("R1 first strobe cycle", first, 4);
    tag = "R2"; step(40);
    tag = "R5";
    align_req = 1; step(30); align_req = 0; step(8);
    tag = "R6";
    for (int k = 0; k < 5; k++) begin align_req = 1; step(5); align_req = 0; step(5); end
    tag = "R7"; fsel = 3'd4; rpt = 4'd11; step(3); tag = "R2"; step(40);
    tag = "R6";
    for (int k = 0; k < 12; k++) begin align_req = 1; step(11); align_req = 0; step(11); end
    tag = "R7"; fsel = 3'd2; rpt = 4'd7; step(5);
    for (int k = 0; k < 8; k++) begin align_req = 1; step(8); align_req = 0; step(8); end
    tag = "R7"; fsel = 3'd3; rpt = 4'd9; step(2);
    for (int k = 0; k < 10; k++) begin align_req = 1; step(9); align_req = 0; step(9); end
    tag = "R7"; fsel = 3'd1; rpt = 4'd6; step(3);
    for (int k = 0; k < 7; k++) begin align_req = 1; step(7); align_req = 0; step(7); end
    tag = "R3"; fsel = 3'd5; step(12); fsel = 3'd7; step(12);
    tag = "R4"; fsel = 3'd0; rpt = 4'd3; step(12);
    rpt = 4'd0; step(8); rpt = 4'd12; step(8);
    fsel = 3'd4; rpt = 4'd8; step(15);
    tag = "R7"; fsel = 3'd0; rpt = 4'd1; step(4); rpt = 4'd4; step(20);
    tag = "R8"; byp_en = 1; byp_ddr = 0; step(16); byp_ddr = 1; step(16);
    tag = "R7"; byp_en = 0; step(30);
    report();
  end
endmodule